// File: doc/BRIEF.md
# Buffered PWM Channel with Delayed Matches

This block is one pulse-width-modulation channel with its own period counter. A prescaler produces a tick every 1 to 4 system clocks, and the counter advances only on these ticks. It runs from 1 up to the period value, then returns to 1, and it never holds zero. Two active registers control the waveform: a leading-edge value and a period value. Compares against them set the pin to its active level and return it to its idle level. Each compare acts on the output one tick late, when the counter leaves the matching value.

Software never writes the active registers directly. It writes two shadow registers at any time. The channel copies them into the active pair at each period wrap, and continuously while the channel is disabled. A leading-edge value of zero selects a true 0% duty cycle. In that case the compare is treated as a match on count 1, taken at the start of the period. That start-of-period event overrides the coincident period-end event, so the pin never pulses. A polarity input chooses which pin level counts as active.

Top module: `bufpwm_chan`

## Requirements
- R1: While `rst` is high, or while `en` is low, the pin settles to the idle level (equal to `pol`) within one clock. `a_match` and `b_match` are 0 while `en` is low. The counter is held at 1, and the prescaler phase is held at 0.
- R2: `psc_sel` value s gives a ratio of s+1. With `en` high, the counter advances on every (s+1)-th clock, counting from the first clock edge that sees `en` high.
- R3: With `en` high, the counter never holds zero. It counts 1, 2, ... up to the period value, and the next tick returns it to 1. `b_match` is high while the count equals the period value.
- R4: When 0 < A < B, the pin goes to the active level on the tick that moves the counter off A. This is one tick after the count first equals A.
- R5: The pin returns to the idle level on the tick that moves the counter off B. This is one tick after the count equals B.
- R6: When A equals B, the active event wins over the coincident idle event. After the first such tick, the pin stays at the active level (100% duty).
- R7: When A is 0, the pin stays at the idle level for every period with no transition, because the start-of-period event masks the period-end event. `a_match` then reports a count of 1.
- R8: The pin level equals the internal level XOR `pol`. With `pol`=0 the active level is high; with `pol`=1 every level is inverted.
- R9: Writes to the shadow registers have no effect on the waveform until the next period wrap. At that wrap they become the active A and B.
- R10: `a_match` is high while `en` is high and the count equals A, or equals 1 when A is 0.
- R11: With `en` high and `pol` unchanged, the pin changes only on a clock edge that carries a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel run enable; low holds counter, prescaler and pin at rest |
| psc_sel | input | PSW | Prescaler select, ratio = value + 1 |
| pol | input | 1 | Output sense; 0 means active level is high |
| a_wr | input | 1 | Write strobe for the leading-edge shadow register |
| a_wdata | input | CW | Leading-edge shadow write data |
| b_wr | input | 1 | Write strobe for the period shadow register |
| b_wdata | input | CW | Period shadow write data |
| pin | output | 1 | Registered output level |
| a_match | output | 1 | Count equals effective leading-edge value |
| b_match | output | 1 | Count equals period value |

## Verification
The bench sweeps every leading-edge value from 0 to the period, for periods 1 to 5, at all four prescaler ratios and both polarities. Each clock is compared against a waveform computed arithmetically from the tick count. This exposes a design that moves the pin on the compare itself rather than one tick later, and one that lets the period edge win when A equals B, which breaks 100% duty. It also exposes a design that lets A = 0 produce a one-tick pulse or an extra transition at the wrap. A separate run rewrites the shadow leading edge in the middle of a period. A design that loads the shadow early would shift the current period's edge instead of the next one.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;

  // internal output level, before polarity is applied
  typedef enum logic {
    LVL_IDLE   = 1'b0,
    LVL_ACTIVE = 1'b1
  } lvl_e;

  // per-clock output events produced by the compare stage
  typedef struct packed {
    logic zero_rise;  // start-of-period event of a zero leading edge
    logic a_fall;     // counter leaving the leading-edge value
    logic b_fall;     // counter leaving the period value
  } evt_t;

endpackage

// File: rtl/bufpwm_prescaler.sv
module bufpwm_prescaler #(
  parameter int PSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [PSW-1:0] sel,
  output logic           tick
);

  logic [PSW-1:0] div_q;

  assign tick = en && (div_q == sel);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/bufpwm_regs.sv
module bufpwm_regs #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic          a_wr,
  input  logic [CW-1:0] a_wdata,
  input  logic          b_wr,
  input  logic [CW-1:0] b_wdata,
  output logic [CW-1:0] a_act,
  output logic [CW-1:0] b_act,
  output logic [CW-1:0] a_nxt
);

  localparam int NREG = 2;  // index 0: leading edge, index 1: period

  logic [NREG-1:0]         wr;
  logic [NREG-1:0][CW-1:0] wdat;
  logic [NREG-1:0][CW-1:0] sh_q;
  logic [NREG-1:0][CW-1:0] act_q;

  assign wr   = {b_wr, a_wr};
  assign wdat = {b_wdata, a_wdata};

  for (genvar g = 0; g < NREG; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst)        sh_q[g] <= '0;
      else if (wr[g]) sh_q[g] <= wdat[g];
    end

    always_ff @(posedge clk) begin
      if (rst)               act_q[g] <= '0;
      else if (!en || load)  act_q[g] <= sh_q[g];
    end
  end

  assign a_act = act_q[0];
  assign b_act = act_q[1];
  assign a_nxt = sh_q[0];

endmodule

// File: rtl/bufpwm_counter.sv
module bufpwm_counter
  import bufpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] a_act,
  input  logic [CW-1:0] b_act,
  input  logic [CW-1:0] a_nxt,
  output logic [CW-1:0] cnt,
  output logic          wrap_tick,
  output evt_t          evt,
  output logic          a_hit,
  output logic          b_hit
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] a_eff;
  logic [CW-1:0] b_eff;
  logic          a_zero;

  assign a_zero    = (a_act == '0);
  assign a_eff     = a_zero ? ONE : a_act;
  assign b_eff     = (b_act == '0) ? ONE : b_act;
  assign wrap_tick = tick && (cnt_q >= b_eff);

  always_ff @(posedge clk) begin
    if (rst || !en)     cnt_q <= ONE;
    else if (wrap_tick) cnt_q <= ONE;
    else if (tick)      cnt_q <= cnt_q + ONE;
  end

  // a compare is held for a whole tick; its falling edge is the tick that
  // moves the counter off the matching value
  assign a_hit = (cnt_q == a_eff);
  assign b_hit = (cnt_q == b_eff);

  always_comb begin
    evt.a_fall    = tick && !a_zero && a_hit;
    evt.b_fall    = tick && b_hit;
    evt.zero_rise = wrap_tick && (a_nxt == '0);
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/bufpwm_outff.sv
module bufpwm_outff
  import bufpwm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pol,
  input  evt_t evt,
  output lvl_e lvl,
  output logic pin
);

  lvl_e lvl_q;
  lvl_e lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (!en || evt.zero_rise) lvl_d = LVL_IDLE;    // zero edge masks period edge
    else if (evt.a_fall)      lvl_d = LVL_ACTIVE;  // leading edge wins a tie
    else if (evt.b_fall)      lvl_d = LVL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LVL_IDLE;
      pin   <= pol;
    end else begin
      lvl_q <= lvl_d;
      pin   <= logic'(lvl_d) ^ pol;
    end
  end

  assign lvl = lvl_q;

endmodule

// File: rtl/bufpwm_chan.sv
module bufpwm_chan
  import bufpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [PSW-1:0] psc_sel,
  input  logic           pol,
  input  logic           a_wr,
  input  logic [CW-1:0]  a_wdata,
  input  logic           b_wr,
  input  logic [CW-1:0]  b_wdata,
  output logic           pin,
  output logic           a_match,
  output logic           b_match
);

  logic          tick;
  logic          wrap_tick;
  logic [CW-1:0] a_act;
  logic [CW-1:0] b_act;
  logic [CW-1:0] a_nxt;
  logic [CW-1:0] cnt;
  logic          a_hit;
  logic          b_hit;
  evt_t          evt;
  lvl_e          lvl;

  bufpwm_prescaler #(.PSW(PSW)) u_psc (
    .clk(clk), .rst(rst), .en(en), .sel(psc_sel), .tick(tick)
  );

  bufpwm_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .en(en), .load(wrap_tick),
    .a_wr(a_wr), .a_wdata(a_wdata), .b_wr(b_wr), .b_wdata(b_wdata),
    .a_act(a_act), .b_act(b_act), .a_nxt(a_nxt)
  );

  bufpwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .a_act(a_act), .b_act(b_act), .a_nxt(a_nxt),
    .cnt(cnt), .wrap_tick(wrap_tick), .evt(evt),
    .a_hit(a_hit), .b_hit(b_hit)
  );

  bufpwm_outff u_out (
    .clk(clk), .rst(rst), .en(en), .pol(pol), .evt(evt),
    .lvl(lvl), .pin(pin)
  );

  assign a_match = en && a_hit;
  assign b_match = en && b_hit;

endmodule

// File: rtl/bufpwm_chk.sv
module bufpwm_chk
  import bufpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           pol,
  input logic [PSW-1:0] psc_sel,
  input logic           tick,
  input logic           wrap_tick,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  a_act,
  input logic [CW-1:0]  b_act,
  input lvl_e           lvl,
  input logic           pin
);

  // R3
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

  // R11
  pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tick && $stable(pol)) |=> $stable(pin));

  // R7
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && a_act == '0) |-> (lvl == LVL_IDLE));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(wrap_tick)) |-> $stable(a_act));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && psc_sel != '0) |=> (!tick || !$stable(psc_sel)));

  // R6
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && a_act == b_act && a_act != '0 && lvl == LVL_ACTIVE && !wrap_tick)
      |=> (lvl == LVL_ACTIVE));

endmodule

bind bufpwm_chan bufpwm_chk #(.CW(CW), .PSW(PSW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pol(pol), .psc_sel(psc_sel),
  .tick(tick), .wrap_tick(wrap_tick), .cnt(cnt),
  .a_act(a_act), .b_act(b_act), .lvl(lvl), .pin(pin)
);

// File: tb/test_bufpwm_chan.sv
module test_bufpwm_chan;

  localparam int CW  = 16;
  localparam int PSW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           en = 1'b0;
  logic [PSW-1:0] psc_sel = '0;
  logic           pol = 1'b0;
  logic           a_wr = 1'b0;
  logic [CW-1:0]  a_wdata = '0;
  logic           b_wr = 1'b0;
  logic [CW-1:0]  b_wdata = '0;
  logic           pin;
  logic           a_match;
  logic           b_match;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bufpwm_chan #(.CW(CW), .PSW(PSW)) i_bufpwm_chan (
    .clk(clk), .rst(rst), .en(en), .psc_sel(psc_sel), .pol(pol),
    .a_wr(a_wr), .a_wdata(a_wdata), .b_wr(b_wr), .b_wdata(b_wdata),
    .pin(pin), .a_match(a_match), .b_match(b_match)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // internal level (1 = active) after t ticks from enable, period b, edge a
  function automatic int exp_lvl(input int a, input int b, input int t);
    if (a == 0) return 0;
    if (t < a) return 0;
    if (a == b) return 1;
    return ((t % b) >= a) ? 1 : 0;
  endfunction

  task automatic run_cfg(input int a, input int b, input int sel, input int p);
    int ratio;
    int aeff;
    ratio = sel + 1;
    aeff  = (a == 0) ? 1 : a;
    @(negedge clk);
    en = 1'b0;
    pol = p[0];
    psc_sel = PSW'(sel);
    a_wr = 1'b1; a_wdata = CW'(a);
    b_wr = 1'b1; b_wdata = CW'(b);
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(p != 0 ? "R8" : "R1", int'(pin), p);
    chk("R1", int'(a_match), 0);
    en = 1'b1;
    for (int m = 1; m <= 3 * b * ratio + 2; m++) begin
      int t;
      int el;
      int cnt_e;
      string tg;
      @(negedge clk);
      t = m / ratio;
      el = exp_lvl(a, b, t);
      cnt_e = (t % b) + 1;
      if (m % ratio != 0) tg = "R11";
      else if (a == 0)    tg = "R7";
      else if (a == b)    tg = "R6";
      else if (el != 0)   tg = "R4";
      else                tg = "R5";
      chk(tg, int'(pin), el ^ p);
      chk("R10", int'(a_match), (cnt_e == aeff) ? 1 : 0);
      chk(ratio > 1 ? "R2" : "R3", int'(b_match), (cnt_e == b) ? 1 : 0);
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  // leading edge rewritten mid-period: 4 -> 2 -> 0, period 8, ratio 1
  task automatic run_shadow();
    @(negedge clk);
    en = 1'b0; pol = 1'b0; psc_sel = '0;
    a_wr = 1'b1; a_wdata = CW'(4);
    b_wr = 1'b1; b_wdata = CW'(8);
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    for (int m = 1; m <= 30; m++) begin
      int e;
      @(negedge clk);
      if (m < 8)       e = (m >= 4) ? 1 : 0;
      else if (m < 16) e = ((m - 8) >= 2) ? 1 : 0;
      else             e = 0;
      chk("R9", int'(pin), e);
      a_wr = 1'b0;
      if (m == 2)  begin a_wr = 1'b1; a_wdata = CW'(2); end
      if (m == 10) begin a_wr = 1'b1; a_wdata = CW'(0); end
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(pin), 0);
    chk("R1", int'(a_match), 0);
    chk("R1", int'(b_match), 0);

    // edge 4, period 8, ratio 2: one-tick lag on both edges
    run_cfg(4, 8, 1, 0);

    for (int sel = 0; sel < 4; sel++)
      for (int p = 0; p < 2; p++)
        for (int b = 1; b <= 5; b++)
          for (int a = 0; a <= b; a++)
            run_cfg(a, b, sel, p);

    run_shadow();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule